// File: doc/BRIEF.md
# Card Interface Status, Mask and Interrupt Register Unit

This block is the memory-mapped register front end of a memory-card host interface. It decodes a simple word-addressed register bus and keeps the configuration words that the command and data engines consume: the power and clock bytes, the command argument, the command word, the data timer, the data length and the data control byte. It also collects completion and error events from those engines into a sticky status word and presents them to software.

The command and data engines report events through single-cycle set pulses on the eleven low status flags. The data engine also drives eleven live FIFO flags, which appear in status bits 21:11 exactly as driven. Software clears sticky flags by writing ones to a clear register. Two independent mask registers each gate the status word onto their own interrupt line. A read-only identification window returns one byte per word address. Reads return data one cycle after the read strobe.

Top module: `card_reg_unit`

## Requirements
- R1: `irqOut[0]` is high exactly when the status word (sticky bits 10:0, live bits 21:11) ANDed with mask register 0 (offset 0x3C) is nonzero; the line follows a status or mask change by one clock.
- R2: `irqOut[1]` is computed the same way from mask register 1 (offset 0x40), independently of mask 0.
- R3: A write to the clear register (offset 0x38) clears each sticky flag whose bit is 1 in the written value, only within bits 10:0; the live FIFO flags in bits 21:11 and the interrupts they cause are unchanged.
- R4: When a set pulse and a clear write address the same sticky bit in the same cycle, the bit ends up set.
- R5: The power register (0x00) and clock register (0x04) keep only bits 7:0 of a write and read back zero-extended.
- R6: Reads from word offsets 0xFE0 through 0xFFC return, in ascending address order, the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R7: After reset every stored register, the status word's sticky flags and both masks are zero, and both interrupt lines are low.
- R8: Reads from unmapped offsets (for example 0x10, 0x38, 0x44) return zero, and writes to unmapped offsets change no register.
- R9: A sticky flag set by a one-cycle pulse on `setPulse` (bit 0 command CRC fail, 2 command timeout, 6 response end, 7 command sent, 8 data end, 10 block end) stays set until cleared; status reads at offset 0x34.
- R10: The argument (0x08) and data timer (0x24) keep all 32 bits, the command word (0x0C) keeps bits 10:0, the data length (0x28) bits 15:0 and the data control (0x2C) bits 7:0, each readable and visible on its output port.
- R11: `rdData` is loaded in the clock edge where `rdEn` is high and holds its value while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the accessed word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| setPulse | input | 11 | Set pulses for sticky status flags 10:0 |
| fifoFlags | input | 11 | Live FIFO flags shown in status bits 21:11 |
| irqOut | output | 2 | Masked interrupt lines |
| pwrByte | output | 8 | Stored power byte |
| clkByte | output | 8 | Stored clock byte |
| cmdArg | output | 32 | Stored command argument |
| cmdWord | output | 11 | Stored command word |
| dataTimer | output | 32 | Stored data timer |
| dataLen | output | 16 | Stored data length |
| dataCtl | output | 8 | Stored data control byte |

## Verification
The hardest state to reach from the ports is a set pulse and a clear write landing on the same sticky bit in the very same clock edge, because the two come from unrelated sources. The bench drives both in one cycle from a dedicated task and then reads the status back. A second awkward case is proving that a clear write of all ones leaves the live FIFO flags and the interrupt they drive untouched; the bench holds FIFO flags high, unmasks one of them and checks both the status read and the interrupt line after the clear.

// File: rtl/card_reg_pkg.sv
package card_reg_pkg;
  parameter int NUM_IRQ  = 2;
  parameter int ADDR_W   = 12;
  parameter int DATA_W   = 32;
  parameter int STICKY_W = 11;
  parameter int LIVE_W   = 11;
  parameter int STATUS_W = STICKY_W + LIVE_W;
  parameter int ID_LEN   = 8;
  localparam int ID_IDX_W  = $clog2(ID_LEN);
  localparam int MASK_IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  localparam logic [ADDR_W-1:0] OFF_POWER = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CLOCK = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_ARG   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CMD   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_TIMER = 12'h024;
  localparam logic [ADDR_W-1:0] OFF_LEN   = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_DCTL  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_CLEAR = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_IDWIN = 12'hFE0;

  typedef enum logic [3:0] {
    SRC_ZERO, SRC_POWER, SRC_CLOCK, SRC_ARG, SRC_CMD, SRC_TIMER,
    SRC_LEN, SRC_DCTL, SRC_STATUS, SRC_MASK, SRC_ID
  } rdSrc_e;

  typedef struct packed {
    logic                  wrPower;
    logic                  wrClock;
    logic                  wrArg;
    logic                  wrCmd;
    logic                  wrTimer;
    logic                  wrLen;
    logic                  wrDctl;
    logic                  wrClear;
    logic [NUM_IRQ-1:0]    wrMask;
    logic                  rdEn;
    rdSrc_e                rdSrc;
    logic [MASK_IDX_W-1:0] maskIdx;
    logic [ID_IDX_W-1:0]   idIdx;
  } regStrb_t;

  function automatic logic [7:0] idByte(input logic [ID_IDX_W-1:0] idx);
    case (idx)
      3'd0: idByte = 8'h81;
      3'd1: idByte = 8'h11;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/card_reg_decode.sv
module card_reg_decode
  import card_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrb_t          strb
);
  localparam int WIN_LSB = ID_IDX_W + 2;

  logic idHit;
  logic [NUM_IRQ-1:0] maskHit;

  assign idHit = (addr[ADDR_W-1:WIN_LSB] == OFF_IDWIN[ADDR_W-1:WIN_LSB]);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_maskDec
      assign maskHit[gi] = (addr == OFF_MASK + ADDR_W'(4 * gi));
    end
  endgenerate

  always_comb begin
    strb         = '0;
    strb.rdSrc   = SRC_ZERO;
    strb.rdEn    = rdEn;
    strb.idIdx   = addr[WIN_LSB-1:2];
    strb.wrPower = wrEn && (addr == OFF_POWER);
    strb.wrClock = wrEn && (addr == OFF_CLOCK);
    strb.wrArg   = wrEn && (addr == OFF_ARG);
    strb.wrCmd   = wrEn && (addr == OFF_CMD);
    strb.wrTimer = wrEn && (addr == OFF_TIMER);
    strb.wrLen   = wrEn && (addr == OFF_LEN);
    strb.wrDctl  = wrEn && (addr == OFF_DCTL);
    strb.wrClear = wrEn && (addr == OFF_CLEAR);
    strb.wrMask  = wrEn ? maskHit : '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (maskHit[i]) begin
        strb.maskIdx = MASK_IDX_W'(i);
      end
    end
    if (idHit)                  strb.rdSrc = SRC_ID;
    else if (|maskHit)          strb.rdSrc = SRC_MASK;
    else begin
      case (addr)
        OFF_POWER: strb.rdSrc = SRC_POWER;
        OFF_CLOCK: strb.rdSrc = SRC_CLOCK;
        OFF_ARG:   strb.rdSrc = SRC_ARG;
        OFF_CMD:   strb.rdSrc = SRC_CMD;
        OFF_TIMER: strb.rdSrc = SRC_TIMER;
        OFF_LEN:   strb.rdSrc = SRC_LEN;
        OFF_DCTL:  strb.rdSrc = SRC_DCTL;
        OFF_STAT:  strb.rdSrc = SRC_STATUS;
        default:   strb.rdSrc = SRC_ZERO;
      endcase
    end
  end

  // R8
  write_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrPower, strb.wrClock, strb.wrArg, strb.wrCmd, strb.wrTimer,
              strb.wrLen, strb.wrDctl, strb.wrClear, strb.wrMask}));

  // R8
  no_write_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ({strb.wrPower, strb.wrClock, strb.wrArg, strb.wrCmd, strb.wrTimer,
                strb.wrLen, strb.wrDctl, strb.wrClear, strb.wrMask} == '0));
endmodule

// File: rtl/card_reg_datapath.sv
module card_reg_datapath
  import card_reg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  regStrb_t            strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [STICKY_W-1:0] setPulse,
  input  logic [LIVE_W-1:0]   fifoFlags,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_IRQ-1:0]  irqOut,
  output logic [7:0]          pwrByte,
  output logic [7:0]          clkByte,
  output logic [31:0]         cmdArg,
  output logic [10:0]         cmdWord,
  output logic [31:0]         dataTimer,
  output logic [15:0]         dataLen,
  output logic [7:0]          dataCtl
);
  logic [STICKY_W-1:0] stickyQ;
  logic [STICKY_W-1:0] clearMask;
  logic [STATUS_W-1:0] statusWord;
  logic [DATA_W-1:0]   maskQ [NUM_IRQ];
  logic [DATA_W-1:0]   rdNext;

  assign statusWord = {fifoFlags, stickyQ};
  assign clearMask  = strb.wrClear ? wrData[STICKY_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrByte   <= '0;
      clkByte   <= '0;
      cmdArg    <= '0;
      cmdWord   <= '0;
      dataTimer <= '0;
      dataLen   <= '0;
      dataCtl   <= '0;
    end else begin
      if (strb.wrPower) pwrByte   <= wrData[7:0];
      if (strb.wrClock) clkByte   <= wrData[7:0];
      if (strb.wrArg)   cmdArg    <= wrData;
      if (strb.wrCmd)   cmdWord   <= wrData[10:0];
      if (strb.wrTimer) dataTimer <= wrData;
      if (strb.wrLen)   dataLen   <= wrData[15:0];
      if (strb.wrDctl)  dataCtl   <= wrData[7:0];
    end
  end

  // Sticky flags: a set pulse overrides a clear of the same bit.
  always_ff @(posedge clk) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= (stickyQ & ~clearMask) | setPulse;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
      always_ff @(posedge clk) begin
        if (!rstN)                maskQ[gi] <= '0;
        else if (strb.wrMask[gi]) maskQ[gi] <= wrData;
      end
      assign irqOut[gi] = |(DATA_W'(statusWord) & maskQ[gi]);

      // R1
      irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rstN)
        (maskQ[gi] == '0) |-> !irqOut[gi]);
      // R2
      irq_follows_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
        ((|($past(setPulse) & maskQ[gi][STICKY_W-1:0])) && $stable(maskQ[gi])) |-> irqOut[gi]);
    end
  endgenerate

  always_comb begin
    case (strb.rdSrc)
      SRC_POWER:  rdNext = DATA_W'(pwrByte);
      SRC_CLOCK:  rdNext = DATA_W'(clkByte);
      SRC_ARG:    rdNext = cmdArg;
      SRC_CMD:    rdNext = DATA_W'(cmdWord);
      SRC_TIMER:  rdNext = dataTimer;
      SRC_LEN:    rdNext = DATA_W'(dataLen);
      SRC_DCTL:   rdNext = DATA_W'(dataCtl);
      SRC_STATUS: rdNext = DATA_W'(statusWord);
      SRC_MASK:   rdNext = maskQ[strb.maskIdx];
      SRC_ID:     rdNext = DATA_W'(idByte(strb.idIdx));
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|setPulse) |=> ((stickyQ & $past(setPulse)) == $past(setPulse)));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrClear |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClear && ((setPulse & wrData[STICKY_W-1:0]) == '0))
      |=> ((stickyQ & $past(wrData[STICKY_W-1:0])) == '0));

  // R5
  power_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPower |=> (pwrByte == $past(wrData[7:0])));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));
endmodule

// File: rtl/card_reg_unit.sv
module card_reg_unit
  import card_reg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [STICKY_W-1:0] setPulse,
  input  logic [LIVE_W-1:0]   fifoFlags,
  output logic [NUM_IRQ-1:0]  irqOut,
  output logic [7:0]          pwrByte,
  output logic [7:0]          clkByte,
  output logic [31:0]         cmdArg,
  output logic [10:0]         cmdWord,
  output logic [31:0]         dataTimer,
  output logic [15:0]         dataLen,
  output logic [7:0]          dataCtl
);
  regStrb_t strb;

  card_reg_decode i_decode (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  card_reg_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .setPulse  (setPulse),
    .fifoFlags (fifoFlags),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .pwrByte   (pwrByte),
    .clkByte   (clkByte),
    .cmdArg    (cmdArg),
    .cmdWord   (cmdWord),
    .dataTimer (dataTimer),
    .dataLen   (dataLen),
    .dataCtl   (dataCtl)
  );
endmodule

// File: tb/test_card_reg_unit.sv
`timescale 1ns/1ps
module test_card_reg_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [10:0] setPulse = '0;
  logic [10:0] fifoFlags = '0;
  logic [1:0]  irqOut;
  logic [7:0]  pwrByte, clkByte, dataCtl;
  logic [31:0] cmdArg, dataTimer;
  logic [10:0] cmdWord;
  logic [15:0] dataLen;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  card_reg_unit i_card_reg_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .setPulse(setPulse), .fifoFlags(fifoFlags),
    .irqOut(irqOut), .pwrByte(pwrByte), .clkByte(clkByte), .cmdArg(cmdArg),
    .cmdWord(cmdWord), .dataTimer(dataTimer), .dataLen(dataLen), .dataCtl(dataCtl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic pulse(input logic [10:0] bits);
    @(negedge clk);
    setPulse = bits;
    @(negedge clk);
    setPulse = '0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(12'h034, v); check("R7 status", v, 32'h0);
    busRead(12'h000, v); check("R7 power", v, 32'h0);
    busRead(12'h03C, v); check("R7 mask0", v, 32'h0);
    busRead(12'h040, v); check("R7 mask1", v, 32'h0);
    busRead(12'h028, v); check("R7 length", v, 32'h0);
    check("R7 irq", {30'h0, irqOut}, 32'h0);
  endtask

  task automatic testStorage();
    logic [31:0] v;
    busWrite(12'h000, 32'h1234_56A5);
    busWrite(12'h004, 32'hFFFF_FF3C);
    busRead(12'h000, v); check("R5 power", v, 32'h0000_00A5);
    busRead(12'h004, v); check("R5 clock", v, 32'h0000_003C);
    check("R5 clock port", {24'h0, clkByte}, 32'h3C);
    busWrite(12'h008, 32'hDEAD_BEEF);
    busWrite(12'h00C, 32'hFFFF_FFFF);
    busWrite(12'h024, 32'h8000_0001);
    busWrite(12'h028, 32'hFFFF_1234);
    busWrite(12'h02C, 32'h0000_01FF);
    busRead(12'h008, v); check("R10 arg", v, 32'hDEAD_BEEF);
    busRead(12'h00C, v); check("R10 cmd", v, 32'h0000_07FF);
    busRead(12'h024, v); check("R10 timer", v, 32'h8000_0001);
    busRead(12'h028, v); check("R10 length", v, 32'h0000_1234);
    busRead(12'h02C, v); check("R10 dctl", v, 32'h0000_00FF);
    check("R10 length port", {16'h0, dataLen}, 32'h1234);
    check("R10 cmd port", {21'h0, cmdWord}, 32'h7FF);
  endtask

  task automatic testIdWindow();
    logic [31:0] v;
    logic [7:0] expId [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      busRead(12'hFE0 + 12'(4 * i), v);
      check("R6 id byte", v, {24'h0, expId[i]});
    end
  endtask

  task automatic testStickyAndIrq();
    logic [31:0] v;
    pulse(11'h040);
    repeat (3) @(negedge clk);
    busRead(12'h034, v); check("R9 sticky response end", v, 32'h0000_0040);
    check("R1 irq0 masked", {31'h0, irqOut[0]}, 32'h0);
    busWrite(12'h03C, 32'h0000_0040);
    check("R1 irq0 on", {31'h0, irqOut[0]}, 32'h1);
    busWrite(12'h040, 32'h0000_0100);
    check("R2 irq1 off", {31'h0, irqOut[1]}, 32'h0);
    pulse(11'h100);
    check("R2 irq1 on", {31'h0, irqOut[1]}, 32'h1);
    busRead(12'h040, v); check("R2 mask1 read", v, 32'h0000_0100);
    busWrite(12'h038, 32'h0000_0040);
    busRead(12'h034, v); check("R3 partial clear", v, 32'h0000_0100);
    check("R1 irq0 after clear", {31'h0, irqOut[0]}, 32'h0);
    check("R2 irq1 unaffected", {31'h0, irqOut[1]}, 32'h1);
  endtask

  task automatic testLiveFlags();
    logic [31:0] v;
    @(negedge clk);
    fifoFlags = 11'h003;
    pulse(11'h085);
    busWrite(12'h03C, 32'h0000_1000);
    check("R1 irq0 from live flag", {31'h0, irqOut[0]}, 32'h1);
    busWrite(12'h038, 32'hFFFF_FFFF);
    busRead(12'h034, v); check("R3 clear spares live flags", v, 32'h0000_1800);
    check("R3 live irq kept", {31'h0, irqOut[0]}, 32'h1);
    check("R3 sticky irq cleared", {31'h0, irqOut[1]}, 32'h0);
    @(negedge clk);
    fifoFlags = '0;
    @(negedge clk);
    check("R1 irq0 follows live flag", {31'h0, irqOut[0]}, 32'h0);
  endtask

  task automatic testSetWins();
    logic [31:0] v;
    busWrite(12'h038, 32'h0000_07FF);
    pulse(11'h001);
    @(negedge clk);
    setPulse = 11'h004;
    addr = 12'h038; wrData = 32'h0000_0005; wrEn = 1'b1;
    @(negedge clk);
    setPulse = '0; wrEn = 1'b0;
    busRead(12'h034, v); check("R4 set beats clear", v, 32'h0000_0004);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    busWrite(12'h044, 32'hFFFF_FFFF);
    busWrite(12'h010, 32'hFFFF_FFFF);
    busRead(12'h044, v); check("R8 read 0x44", v, 32'h0);
    busRead(12'h010, v); check("R8 read 0x10", v, 32'h0);
    busRead(12'h038, v); check("R8 read clear reg", v, 32'h0);
    busRead(12'h040, v); check("R8 mask1 untouched", v, 32'h0000_0100);
    busRead(12'h000, v); check("R8 power untouched", v, 32'h0000_00A5);
    busRead(12'h034, v); check("R8 status untouched", v, 32'h0000_0004);
  endtask

  task automatic testReadHold();
    logic [31:0] v;
    busRead(12'h008, v);
    @(negedge clk);
    addr = 12'h000;
    repeat (2) @(negedge clk);
    check("R11 read data held", rdData, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStorage();
    testIdWindow();
    testStickyAndIrq();
    testLiveFlags();
    testSetWins();
    testUnmapped();
    testReadHold();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule